// File: doc/BRIEF.md
# Host Controller Command and Status Register

This block holds the 32-bit command and status word that sits between host software and the transfer engine of a USB host controller. Software writes through a simple single-cycle write port and reads the current contents combinationally. The transfer engine drives a set of one-cycle event strobes that clear, re-set or advance individual fields as it schedules work.

Two list-filled flags, one for the control list and one for the bulk list, act as a handshake between the two agents. Software raises a flag when it queues a descriptor. The engine drops the flag when it starts the list and raises it again each time it finds a descriptor. A flag still low at the end of a walk therefore halts that list. Each flag drives a start-allowed output.

The block also does three other jobs. It counts scheduling overruns in a 2-bit wrapping counter. It turns a software ownership-change request into a single pulse toward interrupt status. It sequences a software reset with a cycle timer: while the timer runs, a busy output holds the controller in its suspend state and blocks host bus access. The busy output has no effect on the root hub.

Top module: `hc_cmd_stat_reg`

## Requirements
- R1: After the reset input is released, `sw_rd_data` reads 0, and `swrst_busy`, `own_chg_pulse`, `ctrl_start_ok` and `bulk_start_ok` are all 0.
- R2: Bits 31:18 and 15:4 of `sw_rd_data` always read 0, and writing ones to them changes nothing.
- R3: Field 17:16 is an overrun counter. Each cycle with `sched_ovr_evt` high adds 1 to it, wrapping from 3 to 0, whatever the counter's previous value. Software writes to 17:16 are ignored.
- R4: Writing 1 to bit 3 sets the ownership request. `own_chg_pulse` is high for exactly the first cycle in which bit 3 reads 1. `own_xfer_done` clears bit 3. Writing 0 to bit 3 has no effect.
- R5: Writing 1 to bit 1 sets the control-list flag, and writing 1 to bit 2 sets the bulk-list flag. Writing 0 to either bit has no effect.
- R6: `ctrl_start_ok` equals bit 1 and `bulk_start_ok` equals bit 2. A `*_list_begin` strobe clears the matching flag in the next cycle.
- R7: A `*_td_found` strobe sets the matching flag to 1 in the next cycle, even when a begin strobe for that list arrives in the same cycle.
- R8: A software set and a begin-clear of the same flag in the same cycle leave the flag at 1.
- R9: Writing 1 to bit 0 does three things from the next cycle: bits 3:1 and 17:16 are cleared, bit 0 reads 1, and `swrst_busy` is high. Both stay high for exactly RST_CYCLES cycles and then fall together.
- R10: While `swrst_busy` is high, software writes, begin and found strobes, overrun events and `own_xfer_done` all have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_data | output | 32 | Current register contents |
| ctrl_list_begin | input | 1 | Engine starts the control list |
| ctrl_td_found | input | 1 | Engine found a control descriptor |
| bulk_list_begin | input | 1 | Engine starts the bulk list |
| bulk_td_found | input | 1 | Engine found a bulk descriptor |
| ctrl_start_ok | output | 1 | Control list may be processed |
| bulk_start_ok | output | 1 | Bulk list may be processed |
| sched_ovr_evt | input | 1 | Scheduling overrun event |
| own_xfer_done | input | 1 | Ownership changeover finished |
| own_chg_pulse | output | 1 | Ownership-change interrupt pulse |
| swrst_busy | output | 1 | Software reset in progress, bus access blocked |

## Verification
The list-flag handshake is exercised in several ways: with software sets alone, with engine begins alone, and with a begin followed by a found strobe. It is also driven with a software set and a begin in the same cycle, which is what tells the software-priority rule apart from a last-writer rule. Overrun events run through more than four counts, and they arrive both before and after a software write of ones to the counter bits, which separates wrap and write protection from a plain increment. Ownership requests are written twice in a row, which tells an edge-triggered pulse apart from a level. A full reset sequence is timed cycle by cycle while all other inputs are driven, which shows that the field clear, the busy window length and input blocking are separate effects.

// File: rtl/hcsr_pkg.sv
package hcsr_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned B_SWRST   = 0;
  localparam int unsigned B_CTRL    = 1;
  localparam int unsigned B_BULK    = 2;
  localparam int unsigned B_OWN     = 3;
  localparam int unsigned OVR_LO    = 16;
  localparam int unsigned OVR_W     = 2;
  localparam int unsigned N_LISTS   = 2;
  localparam int unsigned L_CTRL    = 0;
  localparam int unsigned L_BULK    = 1;

  typedef enum logic { RS_IDLE = 1'b0, RS_BUSY = 1'b1 } rst_state_e;
endpackage

// File: rtl/hcsr_list_flag.sv
module hcsr_list_flag (
  input  logic clk,
  input  logic arst_n,
  input  logic wipe,
  input  logic hold,
  input  logic sw_set,
  input  logic eng_begin,
  input  logic eng_found,
  output logic flag
);
  logic flag_d, flag_q, flag_en;

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (wipe) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
    end else if (!hold) begin
      if (sw_set || eng_found) begin
        flag_en = 1'b1;
        flag_d  = 1'b1;
      end else if (eng_begin) begin
        flag_en = 1'b1;
        flag_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/hcsr_ovr_counter.sv
module hcsr_ovr_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wipe,
  input  logic             hold,
  input  logic             evt,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (wipe) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (!hold && evt) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/hcsr_own_req.sv
module hcsr_own_req (
  input  logic clk,
  input  logic arst_n,
  input  logic wipe,
  input  logic hold,
  input  logic sw_set,
  input  logic done,
  output logic req,
  output logic pulse
);
  logic req_d, req_q, req_en;
  logic pulse_d, pulse_q;

  always_comb begin
    req_en = 1'b0;
    req_d  = req_q;
    if (wipe) begin
      req_en = 1'b1;
      req_d  = 1'b0;
    end else if (!hold) begin
      if (sw_set) begin
        req_en = 1'b1;
        req_d  = 1'b1;
      end else if (done) begin
        req_en = 1'b1;
        req_d  = 1'b0;
      end
    end
    pulse_d = req_d & ~req_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (req_en) req_q <= req_d;
      pulse_q <= pulse_d;
    end
  end

  assign req   = req_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/hcsr_reset_seq.sv
module hcsr_reset_seq
  import hcsr_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4096
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned TW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(RST_CYCLES - 1);

  rst_state_e st_d, st_q;
  logic [TW-1:0] tmr_d, tmr_q;
  logic          tmr_en;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    unique case (st_q)
      RS_IDLE: if (start) begin
        st_d   = RS_BUSY;
        tmr_d  = '0;
        tmr_en = 1'b1;
      end
      RS_BUSY: begin
        if (tmr_q == LAST) begin
          st_d = RS_IDLE;
        end else begin
          tmr_d  = tmr_q + 1'b1;
          tmr_en = 1'b1;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= RS_IDLE;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign busy = (st_q == RS_BUSY);
endmodule

// File: rtl/hc_cmd_stat_reg.sv
module hc_cmd_stat_reg
  import hcsr_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wr_data,
  output logic [31:0] sw_rd_data,
  input  logic        ctrl_list_begin,
  input  logic        ctrl_td_found,
  input  logic        bulk_list_begin,
  input  logic        bulk_td_found,
  output logic        ctrl_start_ok,
  output logic        bulk_start_ok,
  input  logic        sched_ovr_evt,
  input  logic        own_xfer_done,
  output logic        own_chg_pulse,
  output logic        swrst_busy
);
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic busy, rst_start, wr_ok;
  assign wr_ok     = sw_wr_en & ~busy;
  assign rst_start = wr_ok & sw_wr_data[B_SWRST];

  logic [N_LISTS-1:0] l_set, l_begin, l_found, l_flag;
  assign l_set[L_CTRL]   = wr_ok & sw_wr_data[B_CTRL];
  assign l_set[L_BULK]   = wr_ok & sw_wr_data[B_BULK];
  assign l_begin[L_CTRL] = ctrl_list_begin;
  assign l_begin[L_BULK] = bulk_list_begin;
  assign l_found[L_CTRL] = ctrl_td_found;
  assign l_found[L_BULK] = bulk_td_found;

  for (genvar g = 0; g < N_LISTS; g++) begin : g_list
    hcsr_list_flag u_flag (
      .clk      (clk),
      .arst_n   (arst_n),
      .wipe     (rst_start),
      .hold     (busy),
      .sw_set   (l_set[g]),
      .eng_begin(l_begin[g]),
      .eng_found(l_found[g]),
      .flag     (l_flag[g])
    );
  end

  logic [OVR_W-1:0] ovr_cnt;
  hcsr_ovr_counter #(.CNT_W(OVR_W)) u_ovr (
    .clk   (clk),
    .arst_n(arst_n),
    .wipe  (rst_start),
    .hold  (busy),
    .evt   (sched_ovr_evt),
    .count (ovr_cnt)
  );

  logic own_req;
  hcsr_own_req u_own (
    .clk   (clk),
    .arst_n(arst_n),
    .wipe  (rst_start),
    .hold  (busy),
    .sw_set(wr_ok & sw_wr_data[B_OWN]),
    .done  (own_xfer_done),
    .req   (own_req),
    .pulse (own_chg_pulse)
  );

  hcsr_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk   (clk),
    .arst_n(arst_n),
    .start (rst_start),
    .busy  (busy)
  );

  always_comb begin
    sw_rd_data                          = '0;
    sw_rd_data[B_SWRST]                 = busy;
    sw_rd_data[B_CTRL]                  = l_flag[L_CTRL];
    sw_rd_data[B_BULK]                  = l_flag[L_BULK];
    sw_rd_data[B_OWN]                   = own_req;
    sw_rd_data[OVR_LO +: OVR_W]         = ovr_cnt;
  end

  assign ctrl_start_ok = l_flag[L_CTRL];
  assign bulk_start_ok = l_flag[L_BULK];
  assign swrst_busy    = busy;

  logic unused_wr_bits;
  assign unused_wr_bits = ^sw_wr_data[31:4];
endmodule

// File: rtl/hcsr_chk.sv
module hcsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [31:0] sw_wr_data,
  input logic [31:0] sw_rd_data,
  input logic        ctrl_list_begin,
  input logic        sched_ovr_evt,
  input logic        own_chg_pulse,
  input logic        swrst_busy
);
  logic unused_chk;
  assign unused_chk = ^{sw_wr_data[31:4]};

  always_comb begin
    if (rst_n) begin
      assert ({sw_rd_data[31:18], sw_rd_data[15:4]} == '0)
        else $error("p_rsvd_zero_r2");
    end
  end

  p_ovr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_ovr_evt && !swrst_busy && !(sw_wr_en && sw_wr_data[0]))
    |=> sw_rd_data[17:16] == $past(sw_rd_data[17:16]) + 2'd1);

  p_own_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    own_chg_pulse |-> (sw_rd_data[3] && !$past(sw_rd_data[3])));

  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_wr_data[1] && !sw_wr_data[0] && ctrl_list_begin && !swrst_busy)
    |=> sw_rd_data[1]);

  p_rst_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_wr_data[0] && !swrst_busy)
    |=> (swrst_busy && sw_rd_data[17:16] == 2'd0 && sw_rd_data[3:1] == 3'd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (swrst_busy && $past(swrst_busy)) |-> $stable(sw_rd_data[17:1]));
endmodule

bind hc_cmd_stat_reg hcsr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_wr_en       (sw_wr_en),
  .sw_wr_data     (sw_wr_data),
  .sw_rd_data     (sw_rd_data),
  .ctrl_list_begin(ctrl_list_begin),
  .sched_ovr_evt  (sched_ovr_evt),
  .own_chg_pulse  (own_chg_pulse),
  .swrst_busy     (swrst_busy)
);

// File: tb/hc_cmd_stat_reg_tb_top.sv
module hc_cmd_stat_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RST      = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic [31:0] sw_rd_data;
  logic        ctrl_list_begin, ctrl_td_found, bulk_list_begin, bulk_td_found;
  logic        ctrl_start_ok, bulk_start_ok;
  logic        sched_ovr_evt, own_xfer_done, own_chg_pulse, swrst_busy;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_cmd_stat_reg #(.RST_CYCLES(N_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .ctrl_list_begin(ctrl_list_begin),
    .ctrl_td_found(ctrl_td_found), .bulk_list_begin(bulk_list_begin),
    .bulk_td_found(bulk_td_found), .ctrl_start_ok(ctrl_start_ok),
    .bulk_start_ok(bulk_start_ok), .sched_ovr_evt(sched_ovr_evt),
    .own_xfer_done(own_xfer_done), .own_chg_pulse(own_chg_pulse),
    .swrst_busy(swrst_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_wr_en = 0; sw_wr_data = '0;
    ctrl_list_begin = 0; ctrl_td_found = 0;
    bulk_list_begin = 0; bulk_td_found = 0;
    sched_ovr_evt = 0; own_xfer_done = 0;
  endtask

  // One-cycle write; returns at the negedge after the capturing edge.
  task automatic sw_write(input logic [31:0] d);
    @(negedge clk); sw_wr_en = 1; sw_wr_data = d;
    @(negedge clk); sw_wr_en = 0; sw_wr_data = '0;
  endtask

  task automatic ovr_pulse();
    @(negedge clk); sched_ovr_evt = 1;
    @(negedge clk); sched_ovr_evt = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", sw_rd_data, 32'h0);
    chk("R1 outputs", {28'h0, swrst_busy, own_chg_pulse, ctrl_start_ok, bulk_start_ok}, 32'h0);
  endtask

  task automatic t_reserved();
    sw_write(32'hFFFC_FFF0);
    chk("R2 reserved write ignored", sw_rd_data, 32'h0);
  endtask

  task automatic t_overrun();
    for (int i = 1; i <= 5; i++) begin
      ovr_pulse();
      chk("R3 overrun count", {30'h0, sw_rd_data[17:16]}, 32'(i % 4));
    end
    sw_write(32'h0003_0000);
    chk("R3 counter write ignored", {30'h0, sw_rd_data[17:16]}, 32'd1);
    ovr_pulse(); ovr_pulse();
    chk("R3 counter to 3", {30'h0, sw_rd_data[17:16]}, 32'd3);
    ovr_pulse();
    chk("R3 wrap 3 to 0", {30'h0, sw_rd_data[17:16]}, 32'd0);
  endtask

  task automatic t_own();
    @(negedge clk); sw_wr_en = 1; sw_wr_data = 32'h8;
    @(negedge clk); sw_wr_en = 0; sw_wr_data = '0;
    chk("R4 own bit set", {31'h0, sw_rd_data[3]}, 32'd1);
    chk("R4 pulse first cycle", {31'h0, own_chg_pulse}, 32'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'h0, own_chg_pulse}, 32'd0);
    sw_write(32'h8);
    chk("R4 no pulse on re-set", {31'h0, own_chg_pulse}, 32'd0);
    sw_write(32'h0);
    chk("R4 write 0 no effect", {31'h0, sw_rd_data[3]}, 32'd1);
    @(negedge clk); own_xfer_done = 1;
    @(negedge clk); own_xfer_done = 0;
    chk("R4 done clears", {31'h0, sw_rd_data[3]}, 32'd0);
  endtask

  task automatic t_lists();
    sw_write(32'h2);
    chk("R5 ctrl set", {30'h0, sw_rd_data[2:1]}, 32'b01);
    chk("R6 ctrl start_ok", {31'h0, ctrl_start_ok}, 32'd1);
    sw_write(32'h4);
    chk("R5 bulk set", {30'h0, sw_rd_data[2:1]}, 32'b11);
    chk("R6 bulk start_ok", {31'h0, bulk_start_ok}, 32'd1);
    sw_write(32'h0);
    chk("R5 write 0 no effect", {30'h0, sw_rd_data[2:1]}, 32'b11);
    @(negedge clk); ctrl_list_begin = 1;
    @(negedge clk); ctrl_list_begin = 0;
    chk("R6 ctrl begin clears", {30'h0, ctrl_start_ok, bulk_start_ok}, 32'b01);
    @(negedge clk); ctrl_td_found = 1;
    @(negedge clk); ctrl_td_found = 0;
    chk("R7 ctrl found re-sets", {31'h0, sw_rd_data[1]}, 32'd1);
    @(negedge clk); bulk_list_begin = 1;
    @(negedge clk); bulk_list_begin = 0;
    chk("R6 bulk begin clears", {31'h0, sw_rd_data[2]}, 32'd0);
    @(negedge clk); bulk_list_begin = 1; bulk_td_found = 1;
    @(negedge clk); bulk_list_begin = 0; bulk_td_found = 0;
    chk("R7 found beats begin", {31'h0, bulk_start_ok}, 32'd1);
  endtask

  task automatic t_collide();
    @(negedge clk); ctrl_list_begin = 1;
    @(negedge clk); ctrl_list_begin = 0;
    chk("R6 ctrl cleared pre-collide", {31'h0, sw_rd_data[1]}, 32'd0);
    @(negedge clk); ctrl_list_begin = 1; sw_wr_en = 1; sw_wr_data = 32'h2;
    @(negedge clk); ctrl_list_begin = 0; sw_wr_en = 0; sw_wr_data = '0;
    chk("R8 sw set wins", {31'h0, sw_rd_data[1]}, 32'd1);
  endtask

  task automatic t_swreset();
    int n;
    sw_write(32'h8);
    ovr_pulse();
    sw_write(32'h1);
    chk("R9 fields cleared, bit0 set", sw_rd_data, 32'h1);
    n = 0;
    while (swrst_busy && n < 100) begin
      n++;
      if (n == 3) begin
        // R10: drive everything while busy
        sw_wr_en = 1; sw_wr_data = 32'hE; ctrl_td_found = 1; bulk_td_found = 1;
        sched_ovr_evt = 1; own_xfer_done = 1;
      end
      @(negedge clk);
      idle_inputs();
    end
    chk("R9 busy window length", 32'(n), 32'(N_RST));
    chk("R10 inputs ignored while busy", sw_rd_data, 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reserved();
    t_overrun();
    t_own();
    t_lists();
    t_collide();
    t_swreset();
    sw_write(32'h2);
    chk("R5 writes accepted after reset", {31'h0, sw_rd_data[1]}, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule